// File: doc/BRIEF.md
# Conversion Trigger Combiner and Stretcher

This block gathers the start-of-conversion strobes produced by nine PWM units and turns them into six trigger pins for an external analog-to-digital converter. Each PWM unit offers two strobes, called side A and side B. The units are split into three groups of three. Within a group, every side-A strobe is merged into one pin and every side-B strobe into a second pin.

A converter outside the chip cannot catch a one-cycle strobe reliably. For that reason each merged strobe is widened to a fixed pulse of 32 cycles of the high-speed peripheral clock. A new strobe that arrives while a pulse is still running restarts the 32-cycle window. Each pin has its own polarity bit, so a pin can pulse high from a low idle level or pulse low from a high idle level. Every pin comes straight from a flip-flop, so the pins never glitch.

Top module: `sps_trigger_stretcher`

## Requirements
- R1: Pin index 2g (g = 0, 1, 2) is the side-A pin of group g and is driven by the side-A inputs of units 3g, 3g+1 and 3g+2. Pin index 2g+1 is the side-B pin of the same group and is driven by the side-B inputs of those same units.
- R2: A strobe has no effect on any pin except the one that its side and group select. Pins of other groups and pins of the other side keep their idle level.
- R3: The pin becomes active at the rising clock edge that samples a strobe. It stays active for exactly 32 clock cycles and then returns to idle.
- R4: Polarity bit k selects the level of pin k. A value of 0 gives an active-high pulse with a low idle level. A value of 1 gives an active-low pulse with a high idle level.
- R5: A strobe that is sampled while a pulse is active reloads the window. The pin then stays active for 32 cycles counted from the most recent strobe.
- R6: Strobes that arrive in the same cycle from several units of one group produce one single 32-cycle pulse on that group's pin.
- R7: Reset is synchronous and active-low. While reset is held, every pin sits at its idle level and every stretch count is cleared. No pulse that was running before reset continues after it is released.
- R8: A change of a polarity bit reaches its pin at the next rising edge, whether the pin is idle or active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_a_i | input | 9 | Side-A single-cycle strobes; bit u belongs to PWM unit u |
| trig_b_i | input | 9 | Side-B single-cycle strobes; bit u belongs to PWM unit u |
| pol_i | input | 6 | Polarity per pin; bit k set means pin k is active-low |
| trig_out_o | output | 6 | Stretched trigger pins; 2g is side A and 2g+1 is side B of group g |

## Verification
A strobe sampled at rising edge N changes its pin at that same edge N. The pin stays active after edges N through N+31 and is back at idle after edge N+32. A change of polarity or of reset follows the same timing, one edge after it is applied.

The driver applies stimulus at a falling edge and queues the full six-pin vector expected after the next rising edge. The monitor checks that vector 1 ns after that rising edge, so every result is compared against the pin state of the correct cycle. This single-edge rule covers both edges of the 32-cycle window, retriggering and reset in the middle of a pulse.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int unsigned NUM_UNITS       = 9;
    localparam int unsigned UNITS_PER_GROUP = 3;
    localparam int unsigned NUM_GROUPS      = NUM_UNITS / UNITS_PER_GROUP;
    localparam int unsigned NUM_PINS        = 2 * NUM_GROUPS;
    localparam int unsigned STRETCH_CYCLES  = 32;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    function automatic int unsigned pin_index(input int unsigned grp, input side_e side);
        return 2 * grp + ((side == SIDE_B) ? 1 : 0);
    endfunction
endpackage

// File: rtl/sps_group_merge.sv
module sps_group_merge
    import sps_pkg::*;
#(
    parameter int unsigned UNITS = NUM_UNITS,
    parameter int unsigned PER_GROUP = UNITS_PER_GROUP,
    localparam int unsigned GROUPS = UNITS / PER_GROUP,
    localparam int unsigned PINS = 2 * GROUPS
) (
    input  logic [UNITS-1:0] trig_a_i,
    input  logic [UNITS-1:0] trig_b_i,
    output logic [PINS-1:0]  hit_o
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        // Side A strobes of this group feed the even pin, side B strobes the odd pin.
        assign hit_o[pin_index(g, SIDE_A)] = |trig_a_i[g*PER_GROUP +: PER_GROUP];
        assign hit_o[pin_index(g, SIDE_B)] = |trig_b_i[g*PER_GROUP +: PER_GROUP];
    end
endmodule

// File: rtl/sps_stretch_chan.sv
module sps_stretch_chan
    import sps_pkg::*;
#(
    parameter int unsigned WIDTH = STRETCH_CYCLES,
    localparam int unsigned CW = $clog2(WIDTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic pol_i,
    output logic pin_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pin;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.cnt = '0;
            st_d.pin = pol_i;
        end else begin
            // A strobe always reloads the full window, even when a pulse is already running.
            if (trig_i) begin
                st_d.cnt = CW'(WIDTH);
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
            st_d.pin = (st_d.cnt != '0) ^ pol_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pin_o = st_q.pin;

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> st_q.cnt == CW'(WIDTH));

    // R3
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - CW'(1));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && st_q.cnt == '0) |=> st_q.cnt == '0);
endmodule

// File: rtl/sps_trigger_stretcher.sv
module sps_trigger_stretcher
    import sps_pkg::*;
#(
    parameter int unsigned UNITS = NUM_UNITS,
    parameter int unsigned PER_GROUP = UNITS_PER_GROUP,
    parameter int unsigned WIDTH = STRETCH_CYCLES,
    localparam int unsigned GROUPS = UNITS / PER_GROUP,
    localparam int unsigned PINS = 2 * GROUPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [UNITS-1:0] trig_a_i,
    input  logic [UNITS-1:0] trig_b_i,
    input  logic [PINS-1:0]  pol_i,
    output logic [PINS-1:0]  trig_out_o
);
    logic [PINS-1:0] hit;

    sps_group_merge #(
        .UNITS     (UNITS),
        .PER_GROUP (PER_GROUP)
    ) i_merge (
        .trig_a_i (trig_a_i),
        .trig_b_i (trig_b_i),
        .hit_o    (hit)
    );

    for (genvar k = 0; k < PINS; k++) begin : g_chan
        sps_stretch_chan #(
            .WIDTH (WIDTH)
        ) i_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .trig_i (hit[k]),
            .pol_i  (pol_i[k]),
            .pin_o  (trig_out_o[k])
        );
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp_chk
        // R1
        group_a_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|trig_a_i[g*PER_GROUP +: PER_GROUP]) |=> trig_out_o[2*g] != $past(pol_i[2*g]));
        // R1
        group_b_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|trig_b_i[g*PER_GROUP +: PER_GROUP]) |=> trig_out_o[2*g+1] != $past(pol_i[2*g+1]));
    end

    // R7
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> trig_out_o == $past(pol_i));
endmodule

// File: tb/test_sps_trigger_stretcher.sv
module test_sps_trigger_stretcher;
    localparam int NU = 9;
    localparam int NP = 6;
    localparam int W  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NU-1:0] trig_a = '0;
    logic [NU-1:0] trig_b = '0;
    logic [NP-1:0] pol = '0;
    logic [NP-1:0] trig_out;

    typedef struct {
        logic [NP-1:0] exp;
        string         req;
    } item_t;

    item_t q[$];
    int    mcnt[NP];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;

    always #2 clk = ~clk;

    sps_trigger_stretcher i_sps_trigger_stretcher (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_a_i   (trig_a),
        .trig_b_i   (trig_b),
        .pol_i      (pol),
        .trig_out_o (trig_out)
    );

    // Driver: applies one cycle of stimulus and queues the pin vector due after the next rising edge.
    task automatic step(input logic [NU-1:0] a, input logic [NU-1:0] b,
                        input logic [NP-1:0] p, input logic rst, input string req);
        item_t it;
        @(negedge clk);
        rst_n = ~rst;
        trig_a = a;
        trig_b = b;
        pol = p;
        for (int k = 0; k < NP; k++) begin
            logic hit;
            hit = (k % 2 == 0) ? |a[(k/2)*3 +: 3] : |b[(k/2)*3 +: 3];
            if (rst) mcnt[k] = 0;
            else if (hit) mcnt[k] = W;
            else if (mcnt[k] > 0) mcnt[k] = mcnt[k] - 1;
            it.exp[k] = rst ? p[k] : ((mcnt[k] != 0) ^ p[k]);
        end
        it.req = req;
        q.push_back(it);
    endtask

    task automatic idle(input int n, input logic [NP-1:0] p, input string req);
        for (int i = 0; i < n; i++) step('0, '0, p, 1'b0, req);
    endtask

    // Monitor: compares 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_checks++;
                if (trig_out !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %b expected %b at %0t", it.req, trig_out, it.exp, $time);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NP; k++) mcnt[k] = 0;
        // R7: reset holds idle levels for both polarity settings
        step('0, '0, 6'b000000, 1'b1, "R7 reset idle low");
        step('0, '0, 6'b000000, 1'b1, "R7 reset idle low");
        step('0, '0, 6'b101010, 1'b1, "R7 R4 reset idle mixed");
        step('0, '0, 6'b101010, 1'b1, "R7 R4 reset idle mixed");
        idle(3, 6'b000000, "R4 idle level");
        // R1 R3 R2: unit 0 side A, full window then idle
        step(9'b000000001, '0, 6'b000000, 1'b0, "R1 R3 unit0 A");
        idle(36, 6'b000000, "R3 R2 window");
        // R1: unit 8 side B feeds group 2 pin B
        step('0, 9'b100000000, 6'b000000, 1'b0, "R1 unit8 B");
        idle(34, 6'b000000, "R3 R2 window g2B");
        // R4: active-low pins
        step(9'b000010000, '0, 6'b111111, 1'b0, "R4 unit4 A active low");
        idle(34, 6'b111111, "R4 active low window");
        // R5: retrigger after 20 cycles
        step(9'b000000010, '0, 6'b000000, 1'b0, "R5 first strobe");
        idle(19, 6'b000000, "R5 running");
        step(9'b000000100, '0, 6'b000000, 1'b0, "R5 retrigger");
        idle(36, 6'b000000, "R5 extended window");
        // R6: simultaneous strobes in group 1 side B
        step('0, 9'b000111000, 6'b000000, 1'b0, "R6 simultaneous");
        idle(34, 6'b000000, "R6 single pulse");
        // R5: strobe every cycle for ten cycles
        for (int i = 0; i < 10; i++) step(9'b001000000, '0, 6'b000000, 1'b0, "R5 back to back");
        idle(35, 6'b000000, "R5 tail");
        // R1 R4: all inputs with mixed polarity
        step('1, '1, 6'b010101, 1'b0, "R1 R4 all strobes");
        idle(34, 6'b010101, "R4 all window mixed");
        // R7: reset in the middle of a pulse
        step(9'b000000001, 9'b000000001, 6'b000000, 1'b0, "R7 pre-reset strobe");
        idle(5, 6'b000000, "R7 pre-reset running");
        step('0, '0, 6'b000000, 1'b1, "R7 mid-pulse reset");
        step('0, '0, 6'b000000, 1'b1, "R7 mid-pulse reset");
        idle(35, 6'b000000, "R7 no resumed pulse");
        // R8: polarity change while idle and while active
        idle(2, 6'b001100, "R8 polarity while idle");
        step(9'b000001000, '0, 6'b000000, 1'b0, "R8 strobe");
        idle(5, 6'b000000, "R8 active");
        idle(5, 6'b000100, "R8 flip while active");
        idle(30, 6'b000000, "R8 restore");
        idle(2, 6'b000000, "R3 final idle");
        @(posedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule